// File: doc/BRIEF.md
# Per-Cell Conditional Execution Flag

This block holds the one-bit activity flag of a single processing cell in a SIMD pixel array. All cells receive the same instruction each cycle. A conditional instruction tells each cell to latch a flag from one of two local condition sources, the wave-propagation indicator or the ALU carry, in either true or complemented form. While the cell is in conditional mode, that flag masks the instruction lines that change stored state.

Only a fixed subset of lines is masked: the register-load strobes, the seed-point control, the propagation-space control and one register-read strobe. Every other read or arithmetic strobe passes through whatever the flag holds. A disabled cell therefore still takes part in shared reads and bit-serial arithmetic, but it writes nothing. Leaving conditional mode unmasks every line again. The stored flag is presented on an output so that array readout logic can collect it.

Top module: `act_flag_unit`

## Requirements
- R1: After a synchronous active-high reset, every strobe output, `flag_q` and `ctl_err_q` are 0, and the cell is in unconditional mode.
- R2: Outside conditional mode, every raw strobe appears unchanged on its output one clock after it is presented.
- R3: A capture instruction has `ctl_cond`=1, exactly one of `ctl_sel_prop`/`ctl_sel_carry` set, and `ctl_rd_true`=1 with `ctl_rd_inv`=0. It stores the selected source in the flag at that clock edge. Read bits presented while `ctl_cond`=0 leave the flag unchanged.
- R4: The same instruction with `ctl_rd_inv`=1 and `ctl_rd_true`=0 stores the complement of the selected source.
- R5: `ctl_sel_prop` selects `prop_ind` and `ctl_sel_carry` selects `carry_in`. The source that is not selected has no effect on the stored flag.
- R6: In conditional mode with the flag at 0, `load_q`, `seed_q`, `space_q` and `gread_q` are forced to 0.
- R7: In conditional mode with the flag at 1, the masked strobes pass unchanged.
- R8: `free_raw` is never masked. `free_q` equals `free_raw` one clock later in every mode.
- R9: Masking of an instruction uses the mode and flag stored before that instruction's clock edge. A capture instruction is therefore masked by the previous flag, and its new flag acts from the next instruction on.
- R10: An instruction with `ctl_cond`=0 ends conditional mode. It is itself still masked by the prior state, and every later unconditional instruction passes fully.
- R11: If both select bits or both read bits are set, `ctl_err_q` is 1 for one clock after that instruction and the flag keeps its previous value.
- R12: `flag_q` always shows the stored flag, updated one clock after a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_cond | input | 1 | Conditional-mode bit of the instruction |
| ctl_rd_true | input | 1 | Capture the selected source as is |
| ctl_rd_inv | input | 1 | Capture the selected source complemented |
| ctl_sel_prop | input | 1 | Select the propagation indicator as source |
| ctl_sel_carry | input | 1 | Select the ALU carry as source |
| prop_ind | input | 1 | Propagation indicator of the cell |
| carry_in | input | 1 | Carry bit of the cell's ALU |
| load_raw | input | N_LOAD | Raw register-load strobes |
| seed_raw | input | 1 | Raw seed-point propagation control |
| space_raw | input | 1 | Raw propagation-space control |
| gread_raw | input | 1 | Raw register-read strobe that is masked |
| free_raw | input | N_FREE | Raw read/arithmetic strobes that are never masked |
| load_q | output | N_LOAD | Masked load strobes, registered |
| seed_q | output | 1 | Masked seed control, registered |
| space_q | output | 1 | Masked space control, registered |
| gread_q | output | 1 | Masked register-read strobe, registered |
| free_q | output | N_FREE | Unmasked strobes, registered |
| flag_q | output | 1 | Stored activity flag, for readout |
| ctl_err_q | output | 1 | Illegal control combination seen on the previous instruction |

## Verification
Every output is one register away from its inputs. A strobe, flag value or error pulse caused by the instruction presented before clock edge t can be seen just after t. The mask applied to that instruction is the one stored before t, so a flag change made at edge t shows up first in the strobes of the instruction presented after t. The bench drives each instruction on the falling edge and compares all outputs on the next falling edge. Each table row therefore carries the expected result of its own instruction, worked out from the mode and flag that the earlier rows left behind.

// File: rtl/act_pkg.sv
package act_pkg;

  typedef struct packed {
    logic cond_mode;
    logic rd_true;
    logic rd_inv;
    logic sel_prop;
    logic sel_carry;
  } act_ctl_t;

endpackage

// File: rtl/act_cond_decode.sv
module act_cond_decode
  import act_pkg::*;
(
  input  act_ctl_t ctl,
  input  logic     prop_ind,
  input  logic     carry_in,
  output logic     capture,
  output logic     cap_value,
  output logic     illegal
);

  logic one_sel;
  logic one_rd;
  logic src;

  always_comb begin
    illegal = (ctl.sel_prop & ctl.sel_carry) | (ctl.rd_true & ctl.rd_inv);
    one_sel = ctl.sel_prop ^ ctl.sel_carry;
    one_rd  = ctl.rd_true ^ ctl.rd_inv;
    src     = ctl.sel_prop ? prop_ind : carry_in;
    // Invert on the complemented read.
    cap_value = src ^ ctl.rd_inv;
    capture   = ctl.cond_mode & one_sel & one_rd & ~illegal;
  end

endmodule

// File: rtl/act_flag_reg.sv
module act_flag_reg
  import act_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  act_ctl_t ctl,
  input  logic     capture,
  input  logic     cap_value,
  input  logic     illegal,
  output logic     flag_q,
  output logic     cond_q,
  output logic     err_q,
  output logic     gate_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cond_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (capture) flag_q <= cap_value;
      cond_q <= ctl.cond_mode;
      err_q  <= illegal;
    end
  end

  // The mask comes from registered state only, so it acts on the next instruction.
  assign gate_en = ~cond_q | flag_q;

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    illegal |=> ($stable(flag_q) && err_q)) else $error("illegal hold"); // R11

  AST_NOCOND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cond_mode) |=> $stable(flag_q)) else $error("flag moved"); // R3

endmodule

// File: rtl/act_strobe_gate.sv
module act_strobe_gate #(
  parameter int N_GATED = 11,
  parameter int N_FREE  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate_en,
  input  logic [N_GATED-1:0] gated_raw,
  input  logic [N_FREE-1:0]  free_raw,
  output logic [N_GATED-1:0] gated_q,
  output logic [N_FREE-1:0]  free_q
);

  for (genvar g = 0; g < N_GATED; g++) begin : g_gated
    always_ff @(posedge clk) begin
      if (rst) gated_q[g] <= 1'b0;
      else     gated_q[g] <= gated_raw[g] & gate_en;
    end
  end

  for (genvar f = 0; f < N_FREE; f++) begin : g_free
    always_ff @(posedge clk) begin
      if (rst) free_q[f] <= 1'b0;
      else     free_q[f] <= free_raw[f];
    end
  end

  AST_GATED_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!gate_en) |=> (gated_q == '0)) else $error("masked strobe leaked"); // R6

  AST_GATED_PASS: assert property (@(posedge clk) disable iff (rst)
    gate_en |=> (gated_q == $past(gated_raw))) else $error("strobe lost"); // R7

  AST_FREE_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (free_q == $past(free_raw))) else $error("free strobe changed"); // R8

endmodule

// File: rtl/act_flag_unit.sv
module act_flag_unit
  import act_pkg::*;
#(
  parameter int N_LOAD = 8,
  parameter int N_FREE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_cond,
  input  logic              ctl_rd_true,
  input  logic              ctl_rd_inv,
  input  logic              ctl_sel_prop,
  input  logic              ctl_sel_carry,
  input  logic              prop_ind,
  input  logic              carry_in,
  input  logic [N_LOAD-1:0] load_raw,
  input  logic              seed_raw,
  input  logic              space_raw,
  input  logic              gread_raw,
  input  logic [N_FREE-1:0] free_raw,
  output logic [N_LOAD-1:0] load_q,
  output logic              seed_q,
  output logic              space_q,
  output logic              gread_q,
  output logic [N_FREE-1:0] free_q,
  output logic              flag_q,
  output logic              ctl_err_q
);

  localparam int N_GATED = N_LOAD + 3;

  act_ctl_t           ctl;
  logic               capture;
  logic               cap_value;
  logic               illegal;
  logic               cond_q;
  logic               gate_en;
  logic [N_GATED-1:0] gated_raw;
  logic [N_GATED-1:0] gated_q;

  assign ctl = '{cond_mode: ctl_cond, rd_true: ctl_rd_true, rd_inv: ctl_rd_inv,
                 sel_prop: ctl_sel_prop, sel_carry: ctl_sel_carry};

  act_cond_decode u_decode (
    .ctl       (ctl),
    .prop_ind  (prop_ind),
    .carry_in  (carry_in),
    .capture   (capture),
    .cap_value (cap_value),
    .illegal   (illegal)
  );

  act_flag_reg u_flag (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .capture   (capture),
    .cap_value (cap_value),
    .illegal   (illegal),
    .flag_q    (flag_q),
    .cond_q    (cond_q),
    .err_q     (ctl_err_q),
    .gate_en   (gate_en)
  );

  assign gated_raw = {gread_raw, space_raw, seed_raw, load_raw};

  act_strobe_gate #(.N_GATED(N_GATED), .N_FREE(N_FREE)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .gate_en   (gate_en),
    .gated_raw (gated_raw),
    .free_raw  (free_raw),
    .gated_q   (gated_q),
    .free_q    (free_q)
  );

  assign load_q  = gated_q[N_LOAD-1:0];
  assign seed_q  = gated_q[N_LOAD];
  assign space_q = gated_q[N_LOAD+1];
  assign gread_q = gated_q[N_LOAD+2];

  AST_UNCOND_PASS: assert property (@(posedge clk) disable iff (rst)
    (!cond_q) |=> (load_q == $past(load_raw))) else $error("uncond load"); // R2

  AST_IF_TRUE_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ctl_cond && ctl_rd_true && !ctl_rd_inv && ctl_sel_carry && !ctl_sel_prop)
    |=> (flag_q == $past(carry_in))) else $error("true capture"); // R3

  AST_IF_INV_PROP: assert property (@(posedge clk) disable iff (rst)
    (ctl_cond && ctl_rd_inv && !ctl_rd_true && ctl_sel_prop && !ctl_sel_carry)
    |=> (flag_q == !$past(prop_ind))) else $error("inverted capture"); // R4

endmodule

// File: tb/test_act_flag_unit.sv
module test_act_flag_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ctl = '0;  // {cond, rd_true, rd_inv, sel_prop, sel_carry, prop, carry}
  logic [7:0] load_raw = '0;
  logic [2:0] pg_raw = '0;  // {gread, space, seed}
  logic [3:0] free_raw = '0;
  logic [7:0] load_q;
  logic       seed_q, space_q, gread_q, flag_q, err_q;
  logic [3:0] free_q;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  act_flag_unit #(.N_LOAD(8), .N_FREE(4)) i_act_flag_unit (
    .clk(clk), .rst(rst),
    .ctl_cond(ctl[6]), .ctl_rd_true(ctl[5]), .ctl_rd_inv(ctl[4]),
    .ctl_sel_prop(ctl[3]), .ctl_sel_carry(ctl[2]),
    .prop_ind(ctl[1]), .carry_in(ctl[0]),
    .load_raw(load_raw), .seed_raw(pg_raw[0]), .space_raw(pg_raw[1]),
    .gread_raw(pg_raw[2]), .free_raw(free_raw),
    .load_q(load_q), .seed_q(seed_q), .space_q(space_q), .gread_q(gread_q),
    .free_q(free_q), .flag_q(flag_q), .ctl_err_q(err_q)
  );

  typedef struct packed {
    logic [6:0] ctl;
    logic [7:0] ld;
    logic [2:0] pg;
    logic [3:0] fr;
    logic [7:0] e_ld;
    logic [2:0] e_pg;
    logic [3:0] e_fr;
    logic       e_flag;
    logic       e_err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{7'b0000000, 8'hA5, 3'b111, 4'b1010, 8'hA5, 3'b111, 4'b1010, 1'b0, 1'b0}, // R2
    '{7'b1100110, 8'hFF, 3'b101, 4'b0011, 8'hFF, 3'b101, 4'b0011, 1'b0, 1'b0}, // R3 R9
    '{7'b1000000, 8'h3C, 3'b111, 4'b1111, 8'h00, 3'b000, 4'b1111, 1'b0, 1'b0}, // R6 R8
    '{7'b1010100, 8'h0F, 3'b010, 4'b0001, 8'h00, 3'b000, 4'b0001, 1'b1, 1'b0}, // R4 R9
    '{7'b1000000, 8'h81, 3'b110, 4'b0100, 8'h81, 3'b110, 4'b0100, 1'b1, 1'b0}, // R7
    '{7'b1101100, 8'h11, 3'b001, 4'b0000, 8'h11, 3'b001, 4'b0000, 1'b1, 1'b1}, // R11
    '{7'b1110100, 8'h22, 3'b000, 4'b0000, 8'h22, 3'b000, 4'b0000, 1'b1, 1'b1}, // R11
    '{7'b1101001, 8'h44, 3'b100, 4'b0000, 8'h44, 3'b100, 4'b0000, 1'b0, 1'b0}, // R5
    '{7'b1000000, 8'h77, 3'b111, 4'b1000, 8'h00, 3'b000, 4'b1000, 1'b0, 1'b0}, // R6
    '{7'b1011001, 8'h01, 3'b011, 4'b0000, 8'h00, 3'b000, 4'b0000, 1'b1, 1'b0}, // R5 R4
    '{7'b1100110, 8'h02, 3'b000, 4'b0000, 8'h02, 3'b000, 4'b0000, 1'b0, 1'b0}, // R3
    '{7'b0000000, 8'h99, 3'b111, 4'b0110, 8'h00, 3'b000, 4'b0110, 1'b0, 1'b0}, // R10 R9
    '{7'b0000000, 8'h5A, 3'b111, 4'b0000, 8'h5A, 3'b111, 4'b0000, 1'b0, 1'b0}, // R10
    '{7'b0100101, 8'h01, 3'b000, 4'b0000, 8'h01, 3'b000, 4'b0000, 1'b0, 1'b0}  // R3
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] c, input logic [7:0] ld, input logic [2:0] pg,
                      input logic [3:0] fr);
    ctl = c; load_raw = ld; pg_raw = pg; free_raw = fr;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    ctl = 7'b0000011; load_raw = 8'hFF; pg_raw = 3'b111; free_raw = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "load_q", {24'd0, load_q}, 32'h0);
    chk("R1", "masked ctl", {29'd0, gread_q, space_q, seed_q}, 32'h0);
    chk("R1", "free_q", {28'd0, free_q}, 32'h0);
    chk("R1", "flag_q", {31'd0, flag_q}, 32'h0);
    chk("R1", "ctl_err_q", {31'd0, err_q}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ctl, TBL[i].ld, TBL[i].pg, TBL[i].fr);
      chk("R6/R7/R2", $sformatf("row %0d load_q", i), {24'd0, load_q}, {24'd0, TBL[i].e_ld});
      chk("R6/R7/R2", $sformatf("row %0d seed/space/gread", i),
          {29'd0, gread_q, space_q, seed_q}, {29'd0, TBL[i].e_pg});
      chk("R8", $sformatf("row %0d free_q", i), {28'd0, free_q}, {28'd0, TBL[i].e_fr});
      chk("R12", $sformatf("row %0d flag_q", i), {31'd0, flag_q}, {31'd0, TBL[i].e_flag});
      chk("R11", $sformatf("row %0d ctl_err_q", i), {31'd0, err_q}, {31'd0, TBL[i].e_err});
    end

    // R5: unselected carry does not disturb a capture from prop_ind (IF(P), P=1, C=0)
    step(7'b1101010, 8'h00, 3'b000, 4'h0);
    chk("R5", "flag from prop", {31'd0, flag_q}, 32'h1);
    // R9: first body instruction after capture sees the new flag
    step(7'b1000000, 8'hC3, 3'b111, 4'h0);
    chk("R9", "load after capture", {24'd0, load_q}, 32'hC3);

    // R1: reset in the middle of conditional mode
    ctl = 7'b1000000; load_raw = 8'hFF; pg_raw = 3'b111; free_raw = 4'hF;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "flag after reset", {31'd0, flag_q}, 32'h0);
    chk("R1", "load after reset", {24'd0, load_q}, 32'h0);
    rst = 1'b0;
    // R1: unconditional after reset, so a body-style instruction passes once
    step(7'b1000000, 8'h3E, 3'b010, 4'h0);
    chk("R1", "uncond after reset", {24'd0, load_q}, 32'h3E);
    // now conditional with flag 0: masked
    step(7'b1000000, 8'h3E, 3'b010, 4'h0);
    chk("R6", "masked after reset", {24'd0, load_q}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule